// File: doc/BRIEF.md
# Shift, Rotate and Bit-Test Unit

This is a purely combinational 8-bit unit for the execute stage of a small accumulator CPU. It covers several operations: rotating right through carry, the shift-left that forces the low bit to 1, a circular right rotate of the accumulator, testing a bit, setting a bit, and a nibble rotate. The nibble rotate moves four-bit groups between the accumulator and a memory byte. A fetched byte or register value arrives on the operand input, together with the accumulator, a 3-bit bit index and the current flag byte. Each operation returns a main result, a value to write back to the accumulator and a new flag byte, and each applies its own rules for the flags.

The flag byte is laid out as follows, from bit 7 down to bit 0: sign, zero, undocumented copy of result bit 5, half-carry, undocumented copy of result bit 3, parity/overflow, subtract, carry. Fetching the operand, writing the result back to memory and decoding instructions all happen outside this unit. The caller chooses the operation with a 4-bit code.

Top module: `srb_unit`

## Requirements
- R1: Operation codes 0 and 7 to 15 are unused. For them the result equals the operand, the accumulator output equals the accumulator input and the flag byte passes through unchanged. At most one operation strobe is ever active.
- R2: Code 1, rotate right through carry, gives {carry in, operand[7:1]}. The new carry (flag bit 0) is operand[0].
- R3: For code 1, sign = result[7], zero = (result == 0), parity (bit 2) = 1 when the result has an even count of ones, bit 5 = result[5] and bit 3 = result[3]. Half-carry (bit 4) and subtract (bit 1) are 0.
- R4: Code 2, shift left with the low bit set, gives {operand[6:0], 1}. The new carry is operand[7]. The other flags follow the R3 rules, so zero is always 0.
- R5: Code 3, accumulator rotate right circular, gives {acc[0], acc[7:1]} on both the result and the accumulator output. Carry becomes acc[0], half-carry and subtract are 0, and bits 3 and 5 copy the result. Sign, zero and parity keep their incoming values.
- R6: Code 4, bit test. Zero becomes the inverse of operand[index] and parity equals zero. Half-carry is 1 and subtract is 0. Sign is 1 only when index is 7 and that bit is 1. Carry and bits 3 and 5 keep their incoming values, and the result equals the operand.
- R7: Code 5, bit set, returns the operand with bit [index] forced to 1. The flag byte is unchanged.
- R8: Code 6, nibble rotate. The accumulator output is {acc[7:4], operand[7:4]} and the result (the memory byte) is {operand[3:0], acc[3:0]}.
- R9: For code 6, sign, zero, parity, bit 5 and bit 3 come from the new accumulator value. Half-carry and subtract are 0 and carry keeps its incoming value.
- R10: For every code except 3 and 6, the accumulator output equals the accumulator input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 4 | Operation select |
| operand | input | 8 | Register or memory byte to work on |
| accIn | input | 8 | Current accumulator |
| bitIdx | input | 3 | Bit index for the test and set operations |
| flagsIn | input | 8 | Incoming flag byte |
| result | output | 8 | Main result (memory byte for the nibble rotate) |
| accOut | output | 8 | Accumulator write-back value |
| flagsOut | output | 8 | Updated flag byte |

## Verification
The nibble rotate produces its accumulator and memory results in the same evaluation, and the flags must follow the accumulator half rather than the memory half. The bench drives operand/accumulator pairs whose two halves differ in zero and parity, and scores both outputs and the flags as one item. The bit test with index 7 drives sign and zero from the same bit, so the bench sweeps every index over bytes with bit 7 set and clear. It checks that sign rises only at index 7 while zero and parity move together.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int DATA_W = 8;
  localparam int OP_W   = 4;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int NIB_W  = DATA_W / 2;

  // flag byte positions
  localparam int FLG_S = 7;
  localparam int FLG_Z = 6;
  localparam int FLG_Y = 5;
  localparam int FLG_H = 4;
  localparam int FLG_X = 3;
  localparam int FLG_P = 2;
  localparam int FLG_N = 1;
  localparam int FLG_C = 0;

  // operation codes
  localparam logic [OP_W-1:0] OP_RR_CARRY = 4'd1;
  localparam logic [OP_W-1:0] OP_SHL_SET  = 4'd2;
  localparam logic [OP_W-1:0] OP_ACC_ROR  = 4'd3;
  localparam logic [OP_W-1:0] OP_BIT_TEST = 4'd4;
  localparam logic [OP_W-1:0] OP_BIT_SET  = 4'd5;
  localparam logic [OP_W-1:0] OP_NIB_ROT  = 4'd6;

  typedef struct packed {
    logic rrCarry;
    logic shlSet;
    logic accRor;
    logic bitTest;
    logic bitSet;
    logic nibRot;
  } strobe_t;

  // flags built from a result value, carry supplied by the caller
  function automatic logic [7:0] valueFlags(input logic [DATA_W-1:0] v, input logic c);
    logic [7:0] f;
    f        = '0;
    f[FLG_S] = v[DATA_W-1];
    f[FLG_Z] = (v == '0);
    f[FLG_Y] = v[5];
    f[FLG_X] = v[3];
    f[FLG_P] = ~(^v);
    f[FLG_C] = c;
    return f;
  endfunction
endpackage

// File: rtl/srb_ctrl.sv
module srb_ctrl
  import srb_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output strobe_t         strobe
);
  always_comb begin
    strobe = '0;
    case (opCode)
      OP_RR_CARRY: strobe.rrCarry = 1'b1;
      OP_SHL_SET:  strobe.shlSet  = 1'b1;
      OP_ACC_ROR:  strobe.accRor  = 1'b1;
      OP_BIT_TEST: strobe.bitTest = 1'b1;
      OP_BIT_SET:  strobe.bitSet  = 1'b1;
      OP_NIB_ROT:  strobe.nibRot  = 1'b1;
      default:     strobe = '0;
    endcase
  end

  always_comb begin
    AST_STROBE_ONEHOT: assert ($onehot0(strobe)); // R1
  end
endmodule

// File: rtl/srb_datapath.sv
module srb_datapath
  import srb_pkg::*;
(
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] accIn,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [7:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] accOut,
  output logic [7:0]        flagsOut
);
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] work;
  logic              selBit;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_mask
      assign bitMask[gi] = (bitIdx == IDX_W'(gi));
    end
  endgenerate

  assign selBit = |(operand & bitMask);

  always_comb begin
    result   = operand;
    accOut   = accIn;
    flagsOut = flagsIn;
    work     = '0;
    if (strobe.rrCarry) begin
      work     = {flagsIn[FLG_C], operand[DATA_W-1:1]};
      result   = work;
      flagsOut = valueFlags(work, operand[0]);
    end else if (strobe.shlSet) begin
      work     = {operand[DATA_W-2:0], 1'b1};
      result   = work;
      flagsOut = valueFlags(work, operand[DATA_W-1]);
    end else if (strobe.accRor) begin
      work            = {accIn[0], accIn[DATA_W-1:1]};
      result          = work;
      accOut          = work;
      flagsOut[FLG_C] = accIn[0];
      flagsOut[FLG_H] = 1'b0;
      flagsOut[FLG_N] = 1'b0;
      flagsOut[FLG_X] = work[3];
      flagsOut[FLG_Y] = work[5];
    end else if (strobe.bitTest) begin
      flagsOut[FLG_Z] = ~selBit;
      flagsOut[FLG_P] = ~selBit;
      flagsOut[FLG_H] = 1'b1;
      flagsOut[FLG_N] = 1'b0;
      flagsOut[FLG_S] = selBit & bitMask[DATA_W-1];
    end else if (strobe.bitSet) begin
      result = operand | bitMask;
    end else if (strobe.nibRot) begin
      work     = {accIn[DATA_W-1:NIB_W], operand[DATA_W-1:NIB_W]};
      accOut   = work;
      result   = {operand[NIB_W-1:0], accIn[NIB_W-1:0]};
      flagsOut = valueFlags(work, flagsIn[FLG_C]);
    end
  end

  always_comb begin
    if (strobe.bitSet) begin
      AST_BITSET_ONE: assert ((result & bitMask) == bitMask); // R7
    end
    if (strobe.bitTest) begin
      AST_BITTEST_PZ: assert (flagsOut[FLG_P] == flagsOut[FLG_Z]); // R6
    end
    if (strobe.shlSet) begin
      AST_SHL_NONZERO: assert (!flagsOut[FLG_Z] && result[0]); // R4
    end
    if (strobe.nibRot) begin
      AST_NIB_CARRY: assert (flagsOut[FLG_C] == flagsIn[FLG_C]); // R9
    end
    if (strobe == '0) begin
      AST_PASS_THRU: assert (result == operand && flagsOut == flagsIn); // R1
    end
  end
endmodule

// File: rtl/srb_unit.sv
module srb_unit
  import srb_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic [7:0] operand,
  input  logic [7:0] accIn,
  input  logic [2:0] bitIdx,
  input  logic [7:0] flagsIn,
  output logic [7:0] result,
  output logic [7:0] accOut,
  output logic [7:0] flagsOut
);
  strobe_t strobe;

  srb_ctrl u_ctrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  srb_datapath u_dp (
    .strobe   (strobe),
    .operand  (operand),
    .accIn    (accIn),
    .bitIdx   (bitIdx),
    .flagsIn  (flagsIn),
    .result   (result),
    .accOut   (accOut),
    .flagsOut (flagsOut)
  );
endmodule

// File: tb/srb_unit_tb.sv
module srb_unit_tb;
  logic       clk = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] operand = '0;
  logic [7:0] accIn = '0;
  logic [2:0] bitIdx = '0;
  logic [7:0] flagsIn = '0;
  logic [7:0] result, accOut, flagsOut;

  int compared = 0;
  int mismatched = 0;
  bit driverDone = 0;

  typedef struct {
    logic [7:0] res;
    logic [7:0] acc;
    logic [7:0] flg;
    string      req;
  } item_t;

  item_t sbq[$];

  always #2 clk = ~clk; // 250 MHz

  srb_unit u_dut (
    .opCode(opCode), .operand(operand), .accIn(accIn), .bitIdx(bitIdx),
    .flagsIn(flagsIn), .result(result), .accOut(accOut), .flagsOut(flagsOut)
  );

  function automatic logic evenOnes(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n++;
    return (n % 2) == 0;
  endfunction

  // flag byte: S7 Z6 Y5 H4 X3 P2 N1 C0
  function automatic logic [7:0] pack(input logic s, z, y, h, x, p, n, c);
    return {s, z, y, h, x, p, n, c};
  endfunction

  function automatic item_t model(input logic [3:0] op, input logic [7:0] x,
                                  input logic [7:0] a, input logic [2:0] k,
                                  input logic [7:0] f);
    item_t e;
    logic [7:0] r;
    logic b;
    e.res = x; e.acc = a; e.flg = f; e.req = "R1";
    case (op)
      4'd1: begin // R2 R3
        r = (x >> 1) + (f[0] ? 8'h80 : 8'h00);
        e.res = r;
        e.flg = pack(r[7], r == 0, r[5], 0, r[3], evenOnes(r), 0, x[0]);
        e.req = "R2/R3";
      end
      4'd2: begin // R4
        r = (x << 1) + 8'd1;
        e.res = r;
        e.flg = pack(r[7], r == 0, r[5], 0, r[3], evenOnes(r), 0, x[7]);
        e.req = "R4";
      end
      4'd3: begin // R5
        r = (a >> 1) | (a << 7);
        e.res = r; e.acc = r;
        e.flg = pack(f[7], f[6], r[5], 0, r[3], f[2], 0, a[0]);
        e.req = "R5";
      end
      4'd4: begin // R6
        b = (x >> k) & 8'd1;
        e.flg = pack((k == 3'd7) && b, !b, f[5], 1, f[3], !b, 0, f[0]);
        e.req = "R6";
      end
      4'd5: begin // R7
        e.res = x | (8'd1 << k);
        e.req = "R7";
      end
      4'd6: begin // R8 R9
        r = (a & 8'hF0) | (x >> 4);
        e.acc = r;
        e.res = ((x & 8'h0F) << 4) | (a & 8'h0F);
        e.flg = pack(r[7], r == 0, r[5], 0, r[3], evenOnes(r), 0, f[0]);
        e.req = "R8/R9";
      end
      default: e.req = "R1/R10";
    endcase
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [7:0] x, input logic [7:0] a,
                       input logic [2:0] k, input logic [7:0] f);
    @(posedge clk);
    #1;
    opCode = op; operand = x; accIn = a; bitIdx = k; flagsIn = f;
    sbq.push_back(model(op, x, a, k, f));
  endtask

  task automatic cmp(input string what, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // monitor: compares at the falling edge, after the inputs settled
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        cmp("result", e.req, result, e.res);
        cmp("accOut", (e.req == "R5" || e.req == "R8/R9") ? e.req : "R10", accOut, e.acc);
        cmp("flags", e.req, flagsOut, e.flg);
      end
    end
  end

  initial begin
    logic [7:0] lf;
    lf = 8'h5B;
    // R1 R10: unused codes pass through
    drive(4'd0, 8'hA5, 8'h3C, 3'd2, 8'hD7);
    drive(4'd7, 8'h00, 8'hFF, 3'd7, 8'h00);
    drive(4'd15, 8'h81, 8'h12, 3'd0, 8'hFF);
    // R2 R3: carry in/out, zero result
    drive(4'd1, 8'h01, 8'h00, 3'd0, 8'h00);
    drive(4'd1, 8'h01, 8'h00, 3'd0, 8'h01);
    drive(4'd1, 8'hFE, 8'h00, 3'd0, 8'hFF);
    // R4: top bit to carry, low bit forced
    drive(4'd2, 8'h80, 8'h00, 3'd0, 8'h40);
    drive(4'd2, 8'h7F, 8'h00, 3'd0, 8'h01);
    // R5: S, Z, P keep incoming
    drive(4'd3, 8'h00, 8'h01, 3'd0, 8'h44);
    drive(4'd3, 8'hFF, 8'h50, 3'd0, 8'hBB);
    // R6: every index, with bit 7 set and clear
    for (int k = 0; k < 8; k++) begin
      drive(4'd4, 8'hA5, 8'h00, 3'(k), 8'h29);
      drive(4'd4, 8'h5A, 8'h00, 3'(k), 8'hD6);
    end
    // R7: every index, flags untouched
    for (int k = 0; k < 8; k++) drive(4'd5, 8'h00, 8'h77, 3'(k), 8'(k * 37));
    // R8 R9: halves with different zero/parity
    drive(4'd6, 8'h34, 8'h12, 3'd0, 8'h01);
    drive(4'd6, 8'h0F, 8'h00, 3'd0, 8'hFE);
    drive(4'd6, 8'hF0, 8'h80, 3'd0, 8'h00);
    // mixed pattern across all codes
    for (int i = 0; i < 64; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      drive(4'(i % 16), lf, ~lf ^ 8'(i), 3'(i / 3), lf ^ 8'h3C);
    end
    repeat (3) @(posedge clk);
    driverDone = 1;
  end

  initial begin
    wait (driverDone && sbq.size() == 0);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule